// File: doc/BRIEF.md
# Floppy Drive Polling Sequencer

This block runs the background polling loop of a floppy disk controller. A slot timer visits each logical drive in turn, one fixed-length slot per drive. During a drive's visit the sequencer fires any step pulse that was requested for that drive, with the direction line set as asked. It also samples the drive's ready line and, when ready-change polling is on, records a change as a pending interrupt. Step pulses are issued even when ready polling is off.

The same loop gates two other things. A command byte written by the host drops the "ready for next byte" flag until the loop in progress has finished. After the host reports that the motor-off time has run out, the block counts a further delay in ticks derived from the data rate and raises a power-down request at a loop boundary, provided power-down is enabled. Seek and recalibrate completions and ready changes raise the interrupt line. A sense strobe loads the result byte ST0 for the highest-priority pending event and clears that event.

Top module: `fdd_poll_seq`

## Requirements
- R1: The loop visits drives 0, 1, ... NUM_DRV-1 and then wraps to 0. Each visit lasts SLOT_CYC clock cycles, and `poll_drv_o` shows the drive being visited.
- R2: Any number of step requests made for a drive before its visit produce exactly one STEP pulse, SLOT_CYC cycles wide, during that visit. DIR holds the requested level for the whole pulse (1 on `step_dir_i` gives 1 on `dir_o`). DIR changes only when a pulse is fired. This holds whatever the state of `poll_en_i`.
- R3: With `poll_en_i` high, a change on a drive's ready line seen at its visit latches a pending ready-change for that drive and raises `irq_o`. With `poll_en_i` low the change is not recorded, and it is not reported later when polling is turned back on. `irq_o` falls only after a sense strobe.
- R4: A sense strobe reports the pending seek/recalibrate completion first. Otherwise it reports the lowest-numbered drive with a pending ready change, as ST0 = 11b in bits 7:6, bits 5:2 zero and the drive in bits 1:0 (C0h + drive). With nothing pending it returns 80h. ST0 changes only in the cycle after a sense strobe.
- R5: A seek completion gives ST0 with bits 7:6 = 00, bit 5 = 1, bit 4 = 0, bit 3 = 0, bit 2 = head level and bits 1:0 = drive.
- R6: A recalibrate completion while the drive's TRK0 is inactive sets bit 4 (equipment check) and reports IC 01 (abnormal end). With TRK0 active it reports as in R5.
- R7: A command byte drops `byte_rdy_o` on the next cycle. It stays low until the loop in progress ends, and rises in the first cycle of the drive 0 visit.
- R8: After a motor-off expiry strobe with `pd_en_i` high, `pwr_dn_o` rises at a loop boundary once PD_TICKS rate ticks have passed. It never rises while `pd_en_i` is low, and a command byte clears it.
- R9: The rate tick period is TICK_BASE cycles for rate codes 00 (500 Kbps) and 11 (1 Mbps). It is TICK_BASE*5/3 cycles (rounded) for 01 (300 Kbps) and 2*TICK_BASE cycles for 10 (250 Kbps), so lower rates stretch the power-down wait.
- R10: In reset ST0 is 00h, `irq_o`, `step_o`, `dir_o` and `pwr_dn_o` are 0, and `byte_rdy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| poll_en_i | input | 1 | Enables ready-change detection |
| rdy_i | input | NUM_DRV | Per-drive ready lines |
| trk0_i | input | NUM_DRV | Per-drive track-0 lines |
| step_req_i | input | NUM_DRV | Per-drive step request strobes |
| step_dir_i | input | NUM_DRV | Direction for each step request |
| rate_i | input | 2 | Data-rate code |
| pd_en_i | input | 1 | Power-down enable from the mode setting |
| motor_off_i | input | 1 | Motor-off time expired strobe |
| cmd_byte_i | input | 1 | Host wrote a command byte |
| seek_done_i | input | 1 | Seek or recalibrate completed strobe |
| seek_drv_i | input | 2 | Drive of the completed seek |
| seek_head_i | input | 1 | Head level at end of execution |
| seek_recal_i | input | 1 | Completion was a recalibrate |
| sense_i | input | 1 | Sense-interrupt strobe |
| poll_drv_o | output | 2 | Drive currently visited |
| step_o | output | 1 | Step pulse |
| dir_o | output | 1 | Step direction |
| byte_rdy_o | output | 1 | Ready for next command byte |
| irq_o | output | 1 | Interrupt pending |
| st0_o | output | 8 | Result status byte 0 |
| pwr_dn_o | output | 1 | Power-down request |

## Verification
The assertions check on every cycle that DIR moves only with a fired step, that a pulse starts inside one visit, and that ST0 and the interrupt change only after a sense strobe. They also check that the ready flag and the power-down request rise only at the wrap from the last drive to drive 0, and that power-down never rises without the enable. The bench scenarios are needed for the rest. These are the collapsing of repeated step requests into one pulse of the exact slot width, the lowest-drive-first ordering behind a pending seek, and the suppression of ready changes while polling is off. They also cover the rate-dependent power-down window, which the bench brackets between an earliest and a latest cycle.

// File: rtl/fdd_poll_pkg.sv
package fdd_poll_pkg;
   typedef enum logic [1:0] {
      RATE_500K = 2'b00,
      RATE_300K = 2'b01,
      RATE_250K = 2'b10,
      RATE_1M   = 2'b11
   } rate_e;

   typedef enum logic [1:0] {
      IC_NORMAL   = 2'b00,
      IC_ABNORMAL = 2'b01,
      IC_INVALID  = 2'b10,
      IC_RDY_CHG  = 2'b11
   } icode_e;

   localparam int unsigned DRV_W = 2;
endpackage

// File: rtl/fdd_poll_timer.sv
module fdd_poll_timer #(
   parameter int unsigned NUM_DRV  = 4,
   parameter int unsigned SLOT_CYC = 8
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   output logic [1:0] drv_idx_o,
   output logic       slot_start_o,
   output logic       loop_end_o
);
   localparam int unsigned SW = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
   localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_CYC - 1);
   localparam logic [1:0]    DRV_LAST  = 2'(NUM_DRV - 1);

   logic [SW-1:0] slot_cnt;
   logic          slot_end;

   assign slot_end     = (slot_cnt == SLOT_LAST);
   assign slot_start_o = (slot_cnt == '0);
   assign loop_end_o   = slot_end && (drv_idx_o == DRV_LAST);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         slot_cnt  <= '0;
         drv_idx_o <= '0;
      end else if (slot_end) begin
         slot_cnt  <= '0;
         drv_idx_o <= (drv_idx_o == DRV_LAST) ? 2'd0 : drv_idx_o + 2'd1;
      end else begin
         slot_cnt  <= slot_cnt + SW'(1);
      end
   end
endmodule

// File: rtl/fdd_drive_slot.sv
module fdd_drive_slot (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic visit_i,
   input  logic poll_en_i,
   input  logic step_req_i,
   input  logic step_dir_i,
   input  logic rdy_i,
   input  logic rc_clr_i,
   output logic step_fire_o,
   output logic step_dir_o,
   output logic rc_pend_o
);
   logic step_pend;
   logic rdy_last;
   logic rdy_chg;

   assign step_fire_o = visit_i && step_pend;
   assign rdy_chg     = visit_i && poll_en_i && (rdy_i != rdy_last);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         step_pend  <= 1'b0;
         step_dir_o <= 1'b0;
         rdy_last   <= 1'b0;
         rc_pend_o  <= 1'b0;
      end else begin
         if (step_req_i) begin
            step_pend  <= 1'b1;
            step_dir_o <= step_dir_i;
         end else if (visit_i) begin
            step_pend  <= 1'b0;
         end
         if (visit_i) rdy_last <= rdy_i;
         rc_pend_o <= (rc_pend_o && !rc_clr_i) || rdy_chg;
      end
   end
endmodule

// File: rtl/fdd_pd_timer.sv
module fdd_pd_timer
   import fdd_poll_pkg::*;
#(
   parameter int unsigned TICK_BASE = 3,
   parameter int unsigned PD_TICKS  = 64,
   parameter bit          LOW_RATES = 1'b1
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  rate_e rate_i,
   input  logic  pd_en_i,
   input  logic  motor_off_i,
   input  logic  wake_i,
   input  logic  loop_end_i,
   output logic  pwr_dn_o
);
   localparam int unsigned P_FAST = TICK_BASE;
   localparam int unsigned P_MID  = (TICK_BASE * 5 + 2) / 3;
   localparam int unsigned P_SLOW = TICK_BASE * 2;
   localparam int unsigned TW     = $clog2(P_SLOW + 1);
   localparam int unsigned CW     = $clog2(PD_TICKS + 1);

   logic [TW-1:0] period;
   logic [TW-1:0] tick_cnt;
   logic          tick;
   logic [CW-1:0] pd_cnt;
   logic          armed;

   if (LOW_RATES) begin : g_scaled
      always_comb begin
         case (rate_i)
            RATE_300K: period = TW'(P_MID);
            RATE_250K: period = TW'(P_SLOW);
            default:   period = TW'(P_FAST);
         endcase
      end
   end else begin : g_flat
      assign period = TW'(P_FAST);
   end

   assign tick = (tick_cnt >= period - TW'(1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         tick_cnt <= '0;
         pd_cnt   <= '0;
         armed    <= 1'b0;
         pwr_dn_o <= 1'b0;
      end else begin
         tick_cnt <= tick ? '0 : tick_cnt + TW'(1);
         if (!pd_en_i || wake_i) begin
            armed    <= 1'b0;
            pwr_dn_o <= 1'b0;
         end else begin
            if (motor_off_i) armed <= 1'b1;
            if (loop_end_i && armed && (pd_cnt == CW'(PD_TICKS))) pwr_dn_o <= 1'b1;
         end
         if (!armed || motor_off_i) pd_cnt <= '0;
         else if (tick && (pd_cnt != CW'(PD_TICKS))) pd_cnt <= pd_cnt + CW'(1);
      end
   end
endmodule

// File: rtl/fdd_poll_seq.sv
module fdd_poll_seq
   import fdd_poll_pkg::*;
#(
   parameter int unsigned NUM_DRV   = 4,
   parameter int unsigned SLOT_CYC  = 8,
   parameter int unsigned TICK_BASE = 3,
   parameter int unsigned PD_TICKS  = 64,
   parameter bit          LOW_RATES = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               poll_en_i,
   input  logic [NUM_DRV-1:0] rdy_i,
   input  logic [NUM_DRV-1:0] trk0_i,
   input  logic [NUM_DRV-1:0] step_req_i,
   input  logic [NUM_DRV-1:0] step_dir_i,
   input  logic [1:0]         rate_i,
   input  logic               pd_en_i,
   input  logic               motor_off_i,
   input  logic               cmd_byte_i,
   input  logic               seek_done_i,
   input  logic [1:0]         seek_drv_i,
   input  logic               seek_head_i,
   input  logic               seek_recal_i,
   input  logic               sense_i,
   output logic [1:0]         poll_drv_o,
   output logic               step_o,
   output logic               dir_o,
   output logic               byte_rdy_o,
   output logic               irq_o,
   output logic [7:0]         st0_o,
   output logic               pwr_dn_o
);
   initial begin
      assert (NUM_DRV >= 2 && NUM_DRV <= 4) else $error("NUM_DRV must be 2..4");
      assert (SLOT_CYC >= 2) else $error("SLOT_CYC must be at least 2");
      assert (TICK_BASE >= 1 && PD_TICKS >= 1) else $error("bad power-down timing");
   end

   logic               slot_start;
   logic               loop_end;
   logic [NUM_DRV-1:0] visit;
   logic [NUM_DRV-1:0] step_fire;
   logic [NUM_DRV-1:0] dir_q;
   logic [NUM_DRV-1:0] rc_pend;
   logic [NUM_DRV-1:0] rc_clr;
   logic               rc_hit;
   logic [1:0]         rc_drv;
   logic               trk0_sel;
   logic               seek_pend;
   logic [7:0]         seek_st0;
   logic [7:0]         seek_nxt;
   logic [7:0]         st0_nxt;
   logic               hold_q;
   logic               recal_fail;

   fdd_poll_timer #(.NUM_DRV(NUM_DRV), .SLOT_CYC(SLOT_CYC)) timer_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .drv_idx_o(poll_drv_o),
      .slot_start_o(slot_start), .loop_end_o(loop_end));

   for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
      assign visit[g]  = slot_start && (poll_drv_o == 2'(g));
      assign rc_clr[g] = sense_i && !seek_pend && rc_hit && (rc_drv == 2'(g));
      fdd_drive_slot slot_i (
         .clk_i(clk_i), .rst_ni(rst_ni), .visit_i(visit[g]), .poll_en_i(poll_en_i),
         .step_req_i(step_req_i[g]), .step_dir_i(step_dir_i[g]), .rdy_i(rdy_i[g]),
         .rc_clr_i(rc_clr[g]), .step_fire_o(step_fire[g]), .step_dir_o(dir_q[g]),
         .rc_pend_o(rc_pend[g]));
   end

   // lowest-numbered pending ready change wins
   always_comb begin
      rc_hit = 1'b0;
      rc_drv = 2'd0;
      for (int i = NUM_DRV - 1; i >= 0; i--) begin
         if (rc_pend[i]) begin
            rc_hit = 1'b1;
            rc_drv = 2'(i);
         end
      end
   end

   always_comb begin
      trk0_sel = 1'b0;
      for (int i = 0; i < NUM_DRV; i++)
         if (seek_drv_i == 2'(i)) trk0_sel = trk0_i[i];
   end

   assign recal_fail = seek_recal_i && !trk0_sel;
   assign seek_nxt   = {(recal_fail ? IC_ABNORMAL : IC_NORMAL), 1'b1, recal_fail, 1'b0,
                        seek_head_i, seek_drv_i};

   always_comb begin
      if (seek_pend)   st0_nxt = seek_st0;
      else if (rc_hit) st0_nxt = {IC_RDY_CHG, 4'b0000, rc_drv};
      else             st0_nxt = {IC_INVALID, 6'b000000};
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         step_o    <= 1'b0;
         dir_o     <= 1'b0;
         seek_pend <= 1'b0;
         seek_st0  <= '0;
         st0_o     <= '0;
         hold_q    <= 1'b0;
      end else begin
         if (slot_start) begin
            step_o <= |step_fire;
            if (|step_fire) dir_o <= |(step_fire & dir_q);
         end
         if (seek_done_i) begin
            seek_pend <= 1'b1;
            seek_st0  <= seek_nxt;
         end else if (sense_i) begin
            seek_pend <= 1'b0;
         end
         if (sense_i) st0_o <= st0_nxt;
         if (cmd_byte_i)    hold_q <= 1'b1;
         else if (loop_end) hold_q <= 1'b0;
      end
   end

   assign byte_rdy_o = !hold_q;
   assign irq_o      = seek_pend || (|rc_pend);

   fdd_pd_timer #(.TICK_BASE(TICK_BASE), .PD_TICKS(PD_TICKS), .LOW_RATES(LOW_RATES)) pd_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .rate_i(rate_e'(rate_i)), .pd_en_i(pd_en_i),
      .motor_off_i(motor_off_i), .wake_i(cmd_byte_i), .loop_end_i(loop_end),
      .pwr_dn_o(pwr_dn_o));
endmodule

// File: rtl/fdd_poll_seq_chk.sv
module fdd_poll_seq_chk #(
   parameter int unsigned NUM_DRV = 4
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       sense_i,
   input logic       pd_en_i,
   input logic [1:0] poll_drv_o,
   input logic       step_o,
   input logic       dir_o,
   input logic       byte_rdy_o,
   input logic       irq_o,
   input logic [7:0] st0_o,
   input logic       pwr_dn_o
);
   // R2
   dir_with_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dir_o != $past(dir_o)) |-> step_o);

   // R2
   step_in_visit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(step_o) |-> $stable(poll_drv_o));

   // R4
   st0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(sense_i) |-> $stable(st0_o));

   // R3
   irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o) |-> $past(sense_i));

   // R7
   byte_rdy_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(byte_rdy_o) |-> (poll_drv_o == 2'd0) && ($past(poll_drv_o) == 2'(NUM_DRV - 1)));

   // R8
   pwr_dn_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwr_dn_o) |-> $past(pd_en_i) && (poll_drv_o == 2'd0));
endmodule

bind fdd_poll_seq fdd_poll_seq_chk #(.NUM_DRV(NUM_DRV)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .sense_i(sense_i), .pd_en_i(pd_en_i),
   .poll_drv_o(poll_drv_o), .step_o(step_o), .dir_o(dir_o), .byte_rdy_o(byte_rdy_o),
   .irq_o(irq_o), .st0_o(st0_o), .pwr_dn_o(pwr_dn_o));

// File: tb/fdd_poll_seq_tb_top.sv
`timescale 1ns/1ps
module fdd_poll_seq_tb_top;
   localparam int ND   = 4;
   localparam int SC   = 8;
   localparam int LOOP = ND * SC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          poll_en = 1'b0;
   logic [ND-1:0] rdy = '0, trk0 = '0, step_req = '0, step_dir = '0;
   logic [1:0]    rate = 2'b00;
   logic          pd_en = 1'b0, motor_off = 1'b0, cmd_byte = 1'b0;
   logic          seek_done = 1'b0, seek_head = 1'b0, seek_recal = 1'b0, sense = 1'b0;
   logic [1:0]    seek_drv = 2'd0;
   logic [1:0]    poll_drv;
   logic          step, dir, byte_rdy, irq, pwr_dn;
   logic [7:0]    st0;

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       sense_d = 1'b0;

   always #2.5 clk = ~clk;

   fdd_poll_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .poll_en_i(poll_en), .rdy_i(rdy), .trk0_i(trk0),
      .step_req_i(step_req), .step_dir_i(step_dir), .rate_i(rate), .pd_en_i(pd_en),
      .motor_off_i(motor_off), .cmd_byte_i(cmd_byte), .seek_done_i(seek_done),
      .seek_drv_i(seek_drv), .seek_head_i(seek_head), .seek_recal_i(seek_recal),
      .sense_i(sense), .poll_drv_o(poll_drv), .step_o(step), .dir_o(dir),
      .byte_rdy_o(byte_rdy), .irq_o(irq), .st0_o(st0), .pwr_dn_o(pwr_dn));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // scoreboard monitor: compares ST0 after each sense strobe
   always @(posedge clk) sense_d <= sense;
   always @(negedge clk) begin
      if (sense_d) begin
         if (exp_q.size() == 0) chk("R4 unexpected sense", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), {24'd0, st0}, {24'd0, exp_q.pop_front()});
      end
   end

   task automatic do_sense(input logic [7:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk) sense = 1'b1;
      @(negedge clk) sense = 1'b0;
      @(negedge clk);
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_enter(input logic [1:0] d);
      @(negedge clk);
      while (poll_drv == d) @(negedge clk);
      while (poll_drv != d) @(negedge clk);
   endtask

   task automatic seek(input logic [1:0] d, input logic h, input logic rc);
      @(negedge clk);
      seek_drv = d; seek_head = h; seek_recal = rc; seek_done = 1'b1;
      @(negedge clk) seek_done = 1'b0;
   endtask

   task automatic pulse_cmd();
      @(negedge clk) cmd_byte = 1'b1;
      @(negedge clk) cmd_byte = 1'b0;
   endtask

   task automatic pulse_motor_off();
      @(negedge clk) motor_off = 1'b1;
      @(negedge clk) motor_off = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      cycles(4);
      // R10 reset state
      chk("R10 st0", {24'd0, st0}, 32'h00);
      chk("R10 outs", {27'd0, irq, step, dir, pwr_dn, byte_rdy}, 32'h1);
      rst_n = 1'b1;
      cycles(2);

      // R1 drive order and slot length
      wait_enter(2'd0);
      for (int i = 1; i <= 2 * ND; i++) begin
         cycles(SC);
         chk("R1 drive order", {30'd0, poll_drv}, i % ND);
      end

      // R2 stepping with polling disabled, two requests collapse
      wait_enter(2'd0);
      @(negedge clk) begin step_req[2] = 1'b1; step_dir[2] = 1'b1; end
      @(negedge clk) step_req[2] = 1'b0;
      cycles(2);
      @(negedge clk) step_req[2] = 1'b1;
      @(negedge clk) step_req[2] = 1'b0;
      wait_enter(2'd2);
      @(negedge clk);
      chk("R2 step high", {31'd0, step}, 32'd1);
      chk("R2 dir level", {31'd0, dir}, 32'd1);
      begin
         int w = 0;
         while (step && w < 4 * SC) begin w++; @(negedge clk); end
         chk("R2 pulse width", w, SC);
      end
      begin
         int rises = 0;
         logic prev = step;
         for (int i = 0; i < 2 * LOOP; i++) begin
            @(negedge clk);
            if (step && !prev) rises++;
            prev = step;
         end
         chk("R2 one pulse per request batch", rises, 0);
      end
      @(negedge clk) begin step_req[1] = 1'b1; step_dir[1] = 1'b0; end
      @(negedge clk) step_req[1] = 1'b0;
      wait_enter(2'd1);
      @(negedge clk);
      chk("R2 second step", {30'd0, step, dir}, 32'b10);

      // R3 ready change ignored while polling off
      rdy[0] = 1'b1;
      cycles(2 * LOOP);
      chk("R3 ignored irq", {31'd0, irq}, 32'd0);
      do_sense(8'h80, "R4 empty sense");
      poll_en = 1'b1;
      cycles(2 * LOOP);
      chk("R3 not reported later", {31'd0, irq}, 32'd0);

      // R3/R4 ready changes, lowest first
      rdy[3] = 1'b1; rdy[1] = 1'b1;
      cycles(2 * LOOP);
      chk("R3 irq raised", {31'd0, irq}, 32'd1);
      do_sense(8'hC1, "R4 ready drive 1");
      do_sense(8'hC3, "R4 ready drive 3");
      chk("R3 irq cleared", {31'd0, irq}, 32'd0);
      do_sense(8'h80, "R4 nothing pending");

      // R5 seek, R6 recalibrate
      seek(2'd2, 1'b0, 1'b0);
      chk("R5 irq", {31'd0, irq}, 32'd1);
      do_sense(8'h22, "R5 seek end");
      trk0 = 4'b0001;
      seek(2'd1, 1'b1, 1'b1);
      do_sense(8'h75, "R6 recal no trk0");
      seek(2'd0, 1'b0, 1'b1);
      do_sense(8'h20, "R6 recal with trk0");

      // R4 priority: seek before ready change
      rdy[2] = 1'b1;
      cycles(2 * LOOP);
      seek(2'd3, 1'b1, 1'b0);
      do_sense(8'h27, "R4 seek first");
      do_sense(8'hC2, "R4 then ready");

      // R7 byte ready gated by loop
      wait_enter(2'd0);
      pulse_cmd();
      chk("R7 low after byte", {31'd0, byte_rdy}, 32'd0);
      wait_enter(2'(ND - 1));
      chk("R7 low in loop", {31'd0, byte_rdy}, 32'd0);
      wait_enter(2'd0);
      chk("R7 high at wrap", {31'd0, byte_rdy}, 32'd1);

      // R8/R9 power-down at 500 Kbps
      pd_en = 1'b1; rate = 2'b00;
      pulse_motor_off();
      cycles(178);
      chk("R8 not yet", {31'd0, pwr_dn}, 32'd0);
      cycles(60);
      chk("R8 power down", {31'd0, pwr_dn}, 32'd1);
      pulse_cmd();
      chk("R8 wake clears", {31'd0, pwr_dn}, 32'd0);

      // R9 250 Kbps doubles the wait
      rate = 2'b10;
      pulse_motor_off();
      cycles(238);
      chk("R9 250K still low", {31'd0, pwr_dn}, 32'd0);
      cycles(190);
      chk("R9 250K asserted", {31'd0, pwr_dn}, 32'd1);
      pulse_cmd();

      // R9 300 Kbps
      rate = 2'b01;
      pulse_motor_off();
      cycles(298);
      chk("R9 300K still low", {31'd0, pwr_dn}, 32'd0);
      cycles(72);
      chk("R9 300K asserted", {31'd0, pwr_dn}, 32'd1);
      pulse_cmd();

      // R8 disabled
      pd_en = 1'b0; rate = 2'b00;
      pulse_motor_off();
      cycles(450);
      chk("R8 disabled", {31'd0, pwr_dn}, 32'd0);

      cycles(4);
      finish_run();
   end
endmodule